// File: doc/BRIEF.md
# Serial flash status register write engine

This block is the device-side logic of a serial flash that handles status register writes. It receives commands over a mode-0 SPI slave link (active-low select, serial clock, data in, data out) and keeps a 16-bit status register. A host first sets the write-enable latch. It then issues the status-write command with one or two data bytes. Each byte sent lands only on its writable bits. The update completes after a self-timed busy period of `TW_CYCLES` system clocks.

The SPI pins are sampled by the system clock, which must run at least eight times faster than the serial clock. A status write is committed only when select rises exactly on a byte boundary after one or two data bytes. The new value is held back until the busy period ends. While the block is busy, both status bytes can still be read and polled. Every command other than a status read is ignored during that time.

Top module: `flash_sr_write_engine`

## Requirements
- R1: Commands are 8-bit opcodes followed by data, all MSB first, with SPI mode 0. The device samples `sdi_i` on the rising edge of `sclk_i` and changes `sdo_o` after the falling edge. Opcode 0x01 writes the status register.
- R2: A status write is ignored, and the register is left unchanged, unless the write-enable latch (WEL, bit 1) is 1 when select rises.
- R3: A status write runs only when select rises after exactly 8 or exactly 16 data bits. Any other count (7, 9, 15, 17, ...) discards the command, and WEL keeps its value.
- R4: In the 8-data-bit form, the byte goes to status bits 7:0, and bits 9 (QE) and 8 (SRP1) are forced to 0. In the 16-bit form, the first byte goes to bits 7:0 and the second byte to bits 15:8.
- R5: Only bits 9:2 are writable (BP0=2, BP1=3, BP2=4, TB=5, SEC=6, SRP0=7, SRP1=8, QE=9). Bits 15:10 and bits 1:0 are not changed by the data.
- R6: An accepted status write raises BUSY (bit 0) for `TW_CYCLES` clocks, after which BUSY returns to 0.
- R7: Opcode 0x05 shifts out status bits 7:0 and opcode 0x35 shifts out bits 15:8. Each repeats while select stays low, including while BUSY is 1.
- R8: WEL is cleared to 0 when the busy period ends.
- R9: After reset, all status bits read 0 and `sdo_o` is 0.
- R10: The written value appears only when the busy period ends. Reads during the busy period return the old writable bits, with BUSY and WEL set.
- R11: Opcode 0x06 sets WEL only if select rises after exactly 8 bits. While BUSY is 1, every opcode except 0x05 and 0x35 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock |
| sdi_i | input | 1 | SPI data from host |
| sdo_o | output | 1 | SPI data to host |

## Verification
Two events can fall in the same cycle: the end of the busy period (the register commit and the WEL clear) and an ongoing status read shifting out a bit. The bench starts a long repeating read of status byte 1 right after a write. The read is long enough to span the whole busy period. The first byte read must show BUSY, WEL and the old value, and the last byte must show the new value with BUSY and WEL clear. A second overlap case sends a write-enable command while the block is busy, and WEL must be 0 once the busy period ends.

// File: rtl/sr_wr_pkg.sv
package sr_wr_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR1 = 8'h05;
  localparam logic [7:0] OP_RDSR2 = 8'h35;

  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;

  // BP0..SRP0 in the low byte, SRP1/QE in the high byte
  localparam logic [15:0] WR_MASK = 16'h03FC;
endpackage

// File: rtl/sr_spi_rx.sv
module sr_spi_rx #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             tx_en_i,
  input  logic [7:0]       tx_byte_i,
  output logic             sdo_o,
  output logic             cs_rise_o,
  output logic [7:0]       opcode_o,
  output logic [15:0]      data_o,
  output logic [CNT_W-1:0] bits_o,
  output logic             over_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_OP  = CNT_W'(7);

  logic cs_q, cs_d, sclk_q, sclk_d, sdi_q;
  logic [CNT_W-1:0] cnt_q;
  logic over_q, tx_q;
  logic [15:0] shift_q;
  logic [7:0] op_q;
  logic sclk_rise, sclk_fall;
  logic [2:0] tx_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      cs_d   <= 1'b1;
      sclk_q <= 1'b0;
      sclk_d <= 1'b0;
      sdi_q  <= 1'b0;
    end else begin
      cs_q   <= cs_ni;
      cs_d   <= cs_q;
      sclk_q <= sclk_i;
      sclk_d <= sclk_q;
      sdi_q  <= sdi_i;
    end
  end

  assign sclk_rise = !cs_q && sclk_q && !sclk_d;
  assign sclk_fall = !cs_q && !sclk_q && sclk_d;
  assign tx_idx    = 3'd7 - cnt_q[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      over_q  <= 1'b0;
      tx_q    <= 1'b0;
      shift_q <= '0;
      op_q    <= '0;
    end else if (cs_q) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
      tx_q   <= 1'b0;
      op_q   <= '0;
    end else begin
      if (sclk_rise) begin
        shift_q <= {shift_q[14:0], sdi_q};
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CNT_MAX) over_q <= 1'b1;
        if (cnt_q == CNT_OP && !over_q) op_q <= {shift_q[6:0], sdi_q};
      end
      if (sclk_fall) begin
        tx_q <= tx_en_i && (over_q || cnt_q >= CNT_W'(8)) && tx_byte_i[tx_idx];
      end
    end
  end

  assign sdo_o     = tx_q && !cs_q;
  assign cs_rise_o = cs_q && !cs_d;
  assign opcode_o  = op_q;
  assign data_o    = shift_q;
  assign bits_o    = cnt_q;
  assign over_o    = over_q;
endmodule

// File: rtl/sr_core.sv
module sr_core
  import sr_wr_pkg::*;
#(
  parameter int TW_CYCLES = 200,
  parameter int CNT_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_rise_i,
  input  logic [7:0]       opcode_i,
  input  logic [15:0]      data_i,
  input  logic [CNT_W-1:0] bits_i,
  input  logic             over_i,
  output logic [15:0]      sr_o
);
  localparam int TMR_W = $clog2(TW_CYCLES + 1);

  logic [15:0] sr_q, pend_q, wr_val;
  logic busy_q;
  logic [TMR_W-1:0] tmr_q;
  logic len8, len16, wrsr_go, wren_go;
  logic [7:0] lo_b, hi_b;

  // opcode + 8 or opcode + 16 bits, select rising on the byte edge
  assign len8    = !over_i && bits_i == CNT_W'(16);
  assign len16   = !over_i && bits_i == CNT_W'(24);
  assign wrsr_go = cs_rise_i && opcode_i == OP_WRSR && (len8 || len16)
                   && sr_q[BIT_WEL] && !busy_q;
  assign wren_go = cs_rise_i && opcode_i == OP_WREN && !over_i
                   && bits_i == CNT_W'(8) && !busy_q;

  assign lo_b   = len8 ? data_i[7:0] : data_i[15:8];
  assign hi_b   = len8 ? 8'h00 : data_i[7:0];
  assign wr_val = ({hi_b, lo_b} & WR_MASK) | (sr_q & ~WR_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      pend_q <= '0;
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      if (wren_go) sr_q[BIT_WEL] <= 1'b1;
      if (wrsr_go) begin
        busy_q <= 1'b1;
        tmr_q  <= TMR_W'(TW_CYCLES);
        pend_q <= wr_val;
      end else if (busy_q) begin
        if (tmr_q == TMR_W'(1)) begin
          busy_q        <= 1'b0;
          sr_q[9:2]     <= pend_q[9:2];
          sr_q[BIT_WEL] <= 1'b0;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
      end
    end
  end

  assign sr_o = {sr_q[15:1], busy_q};

  a_r2_busy_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> sr_q[BIT_WEL]);
  a_r8_wel_clear_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> !sr_q[BIT_WEL]);
  a_r5_bits_change_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sr_q[9:2]) |-> $fell(busy_q));
  a_r10_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> $stable(sr_q[9:2]));
  a_r6_busy_until_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tmr_q != TMR_W'(1)) |=> busy_q);
  a_r11_wel_kept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tmr_q != TMR_W'(1)) |=> sr_q[BIT_WEL]);
  a_r5_ro_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(sr_q[15:10]));
endmodule

// File: rtl/flash_sr_write_engine.sv
module flash_sr_write_engine
  import sr_wr_pkg::*;
#(
  parameter int TW_CYCLES = 200,
  parameter int CNT_W     = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);
  logic cs_rise, over, tx_en;
  logic [7:0] opcode, tx_byte;
  logic [15:0] data, sr;
  logic [CNT_W-1:0] bits;

  assign tx_en   = opcode == OP_RDSR1 || opcode == OP_RDSR2;
  assign tx_byte = (opcode == OP_RDSR2) ? sr[15:8] : sr[7:0];

  sr_spi_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .sclk_i    (sclk_i),
    .sdi_i     (sdi_i),
    .tx_en_i   (tx_en),
    .tx_byte_i (tx_byte),
    .sdo_o     (sdo_o),
    .cs_rise_o (cs_rise),
    .opcode_o  (opcode),
    .data_o    (data),
    .bits_o    (bits),
    .over_o    (over)
  );

  sr_core #(.TW_CYCLES(TW_CYCLES), .CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_rise_i (cs_rise),
    .opcode_i  (opcode),
    .data_i    (data),
    .bits_i    (bits),
    .over_i    (over),
    .sr_o      (sr)
  );
endmodule

// File: tb/flash_sr_write_engine_tb.sv
module flash_sr_write_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  flash_sr_write_engine #(.TW_CYCLES(200), .CNT_W(5)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo)
  );

  typedef struct packed {
    logic       wren;
    logic [4:0] nbits;
    logic [7:0] d1;
    logic [7:0] d2;
    logic [7:0] exp1;
    logic [7:0] exp2;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd16, 8'hFF, 8'hFF, 8'hFC, 8'h03},  // R5 mask, 16-bit form
    '{1'b0, 5'd8,  8'h00, 8'h00, 8'hFC, 8'h03},  // R2 no WEL
    '{1'b1, 5'd7,  8'h00, 8'h00, 8'hFE, 8'h03},  // R3 7 bits
    '{1'b0, 5'd9,  8'h00, 8'h00, 8'hFE, 8'h03},  // R3 9 bits
    '{1'b0, 5'd15, 8'h00, 8'h00, 8'hFE, 8'h03},  // R3 15 bits
    '{1'b0, 5'd17, 8'h00, 8'h00, 8'hFE, 8'h03},  // R3 17 bits
    '{1'b0, 5'd8,  8'hA4, 8'h00, 8'hA4, 8'h00},  // R4 8-bit form
    '{1'b1, 5'd16, 8'h03, 8'h02, 8'h00, 8'h02},  // R5 low bits read-only
    '{1'b1, 5'd16, 8'h58, 8'hFD, 8'h58, 8'h01}   // R1 R4 two bytes
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    half();
  endtask

  task automatic cs_high();
    half();
    cs_n = 1'b1;
    half();
  endtask

  task automatic send(input logic [23:0] v, input int n);
    for (int i = 23; i > 23 - n; i--) begin
      sdi = v[i];
      half();
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
  endtask

  task automatic get_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      half();
      b[i] = sdo;
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
  endtask

  task automatic cmd8(input logic [7:0] op, input int n);
    cs_low();
    send({op, 16'h0}, n);
    cs_high();
  endtask

  task automatic wrsr(input logic [7:0] d1, input logic [7:0] d2, input int n);
    cs_low();
    send({8'h01, 16'h0}, 8);
    send({d1, d2, 8'h00}, n);
    cs_high();
  endtask

  task automatic rd(input logic [7:0] op, output logic [7:0] b);
    cs_low();
    send({op, 16'h0}, 8);
    get_byte(b);
    cs_high();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rd(8'h05, s);
      if (!s[0]) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] b, first, last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 sdo after reset", {7'd0, sdo}, 8'h00);
    rd(8'h05, b); chk("R9 sr1 reset", b, 8'h00);
    rd(8'h35, b); chk("R9 sr2 reset", b, 8'h00);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].wren) cmd8(8'h06, 8);
      wrsr(VEC[v].d1, VEC[v].d2, int'(VEC[v].nbits));
      wait_idle();
      rd(8'h05, b); chk($sformatf("R3/R4/R5 vec%0d sr1", v), b, VEC[v].exp1);
      rd(8'h35, b); chk($sformatf("R3/R4/R5 vec%0d sr2", v), b, VEC[v].exp2);
    end

    // R10 R6 R7 R8: read across the busy period, old value then new
    cmd8(8'h06, 8);
    wrsr(8'h24, 8'h02, 16);
    cs_low();
    send({8'h05, 16'h0}, 8);
    get_byte(first);
    for (int k = 0; k < 18; k++) get_byte(b);
    get_byte(last);
    cs_high();
    chk("R10 old value with busy and WEL", first, 8'h5B);
    chk("R8 new value WEL clear", last, 8'h24);
    rd(8'h35, b); chk("R7 sr2 after write", b, 8'h02);

    // R7 continuous sr2 read
    cs_low();
    send({8'h35, 16'h0}, 8);
    get_byte(first);
    get_byte(last);
    cs_high();
    chk("R7 repeat sr2", last, first);

    // R11 write enable during busy is ignored
    cmd8(8'h06, 8);
    wrsr(8'h80, 8'h00, 16);
    cmd8(8'h06, 8);
    wait_idle();
    rd(8'h05, b); chk("R11 wren ignored while busy", b, 8'h80);
    rd(8'h35, b); chk("R4 sr2 second byte zero", b, 8'h00);

    // R11 write enable with wrong bit counts
    cs_low(); send({8'h06, 16'h0}, 9); cs_high();
    rd(8'h05, b); chk("R11 wren 9 bits", b, 8'h80);
    cmd8(8'h06, 7);
    rd(8'h05, b); chk("R11 wren 7 bits", b, 8'h80);
    cmd8(8'h06, 8);
    rd(8'h05, b); chk("R11 wren 8 bits", b, 8'h82);

    // R9 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h05, b); chk("R9 sr1 after second reset", b, 8'h00);
    rd(8'h35, b); chk("R9 sr2 after second reset", b, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule